// File: doc/BRIEF.md
# SPI Event and Interrupt Unit

This unit sits beside an SPI master engine and its two FIFOs. It turns the engine's one-cycle event pulses and the FIFO fill levels into nine sticky event flags, filters them through a per-event mask, and raises one interrupt line for the processor. It also reports whether an unmasked event is pending, whether the receive FIFO is empty, and whether the transmit FIFO is full.

Software programs the mask through a small write port. It reads the event and mask words directly from the output buses, and it acknowledges events by writing ones to the event word.

The two FIFO request events are not pulses. They are raised while a fill level stands on the requesting side of a programmable threshold. An interrupt whose pending status bit is clear is treated by software as spurious. How software recovers from an error is left to software; this unit only records and signals events.

Top module: `spi_evt_irq`

## Requirements
- R1: After reset, `event_o` is all zeros, `mask_o` is all ones (every event masked), and `irq_o` and `irq_pend_o` are 0.
- R2: The event bit positions are: 0 master done, 1 slave done, 2 transmit underflow, 3 transmit overflow, 4 transmit request, 5 receive underflow, 6 receive overflow, 7 receive request, 8 multiple-master error. A 1 on `ev_pulse_i[i]` at a clock edge sets `event_o[i]` from that edge on. The bit stays set after the pulse ends until software clears it.
- R3: A write with `reg_addr_i`=0 clears each event bit whose `reg_wdata_i` bit is 1. Bits written 0 keep their value.
- R4: When a set source and a write-1 clear hit the same event bit at the same edge, the bit is set after that edge.
- R5: A write with `reg_addr_i`=1 loads `reg_wdata_i` into `mask_o`. The mask never stops an event from being recorded in `event_o`.
- R6: `irq_pend_o` is 1 in the same cycle in which any event bit is set whose mask bit is 0. Events whose mask bit is 1 do not raise it.
- R7: `irq_o` equals the value `irq_pend_o` had one clock earlier. It therefore rises one cycle after the unmasked event shows in `event_o`, and it falls one cycle after that event is cleared.
- R8: Event bit 7 (receive request) is set at every edge where `rx_level_i` >= `rx_thr_i`.
- R9: Event bit 4 (transmit request) is set at every edge where `tx_level_i` <= `tx_thr_i`.
- R10: `rx_empty_o` is 1 exactly when `rx_level_i` is 0. `tx_full_o` is 1 exactly when `tx_level_i` equals the FIFO depth.
- R11: A write of all ones with `reg_addr_i`=0 clears every event bit, provided no set source is active at that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ev_pulse_i | input | 9 | Event pulses from the engine, one bit per event position |
| rx_level_i | input | LVL_W | Receive FIFO fill level |
| tx_level_i | input | LVL_W | Transmit FIFO fill level |
| rx_thr_i | input | LVL_W | Receive request threshold |
| tx_thr_i | input | LVL_W | Transmit request threshold |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 1 | 0 selects event clear, 1 selects mask |
| reg_wdata_i | input | 9 | Write data |
| event_o | output | 9 | Sticky event word |
| mask_o | output | 9 | Mask word, 1 suppresses the event |
| irq_o | output | 1 | Registered interrupt line |
| irq_pend_o | output | 1 | Unmasked event pending status |
| rx_empty_o | output | 1 | Receive FIFO empty |
| tx_full_o | output | 1 | Transmit FIFO full |

## Verification
The bench builds the unit with a FIFO depth of 16, which makes the level ports five bits wide. Both thresholds are set to 8, so a level can be placed on either side of the threshold or exactly on it. A level of 16 is also within reach, which tests the full flag at the true depth rather than at a wrapped count. With these values the test can hold the request conditions off while it checks the pulse-driven events. It then enables each request condition on its own.

// File: rtl/spi_evt_pkg.sv
package spi_evt_pkg;
  localparam int NUM_EV   = 9;
  localparam int EV_MDONE = 0;
  localparam int EV_SDONE = 1;
  localparam int EV_TXUND = 2;
  localparam int EV_TXOVF = 3;
  localparam int EV_TXREQ = 4;
  localparam int EV_RXUND = 5;
  localparam int EV_RXOVF = 6;
  localparam int EV_RXREQ = 7;
  localparam int EV_MMERR = 8;
  typedef logic [NUM_EV-1:0] evt_vec_t;
  localparam evt_vec_t REQ_BITS = evt_vec_t'((1 << EV_TXREQ) | (1 << EV_RXREQ));
endpackage

// File: rtl/spi_evt_fifo_req.sv
module spi_evt_fifo_req #(
  parameter int FIFO_DEPTH = 16,
  parameter int LVL_W      = $clog2(FIFO_DEPTH + 1)
) (
  input  logic [LVL_W-1:0] rx_level_i,
  input  logic [LVL_W-1:0] tx_level_i,
  input  logic [LVL_W-1:0] rx_thr_i,
  input  logic [LVL_W-1:0] tx_thr_i,
  output logic             rx_req_o,
  output logic             tx_req_o,
  output logic             rx_empty_o,
  output logic             tx_full_o
);
  localparam logic [LVL_W-1:0] FULL_LVL = LVL_W'(FIFO_DEPTH);

  always_comb begin
    rx_req_o   = (rx_level_i >= rx_thr_i);
    tx_req_o   = (tx_level_i <= tx_thr_i);
    rx_empty_o = (rx_level_i == '0);
    tx_full_o  = (tx_level_i == FULL_LVL);
  end
endmodule

// File: rtl/spi_evt_bit.sv
module spi_evt_bit (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic q_o
);
  logic q_nxt;
  logic q_en;

  // a set at the same edge as a clear leaves the bit set
  always_comb begin
    q_en  = set_i | clr_i;
    q_nxt = set_i | (q_o & ~clr_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    q_o <= 1'b0;
    else if (q_en) q_o <= q_nxt;
  end
endmodule

// File: rtl/spi_evt_mask.sv
module spi_evt_mask #(
  parameter int W = 9
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         we_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] q_nxt;

  always_comb q_nxt = wdata_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    q_o <= '1;
    else if (we_i) q_o <= q_nxt;
  end
endmodule

// File: rtl/spi_evt_irq.sv
module spi_evt_irq
  import spi_evt_pkg::*;
#(
  parameter int FIFO_DEPTH = 16,
  parameter int LVL_W      = $clog2(FIFO_DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_EV-1:0] ev_pulse_i,
  input  logic [LVL_W-1:0]  rx_level_i,
  input  logic [LVL_W-1:0]  tx_level_i,
  input  logic [LVL_W-1:0]  rx_thr_i,
  input  logic [LVL_W-1:0]  tx_thr_i,
  input  logic              reg_we_i,
  input  logic              reg_addr_i,
  input  logic [NUM_EV-1:0] reg_wdata_i,
  output logic [NUM_EV-1:0] event_o,
  output logic [NUM_EV-1:0] mask_o,
  output logic              irq_o,
  output logic              irq_pend_o,
  output logic              rx_empty_o,
  output logic              tx_full_o
);
  logic     rx_req, tx_req;
  evt_vec_t set_vec, clr_vec;
  logic     mask_we;
  logic     irq_nxt;

  spi_evt_fifo_req #(.FIFO_DEPTH(FIFO_DEPTH), .LVL_W(LVL_W)) u_req (
    .rx_level_i (rx_level_i),
    .tx_level_i (tx_level_i),
    .rx_thr_i   (rx_thr_i),
    .tx_thr_i   (tx_thr_i),
    .rx_req_o   (rx_req),
    .tx_req_o   (tx_req),
    .rx_empty_o (rx_empty_o),
    .tx_full_o  (tx_full_o)
  );

  always_comb begin
    set_vec           = ev_pulse_i;
    set_vec[EV_RXREQ] = ev_pulse_i[EV_RXREQ] | rx_req;
    set_vec[EV_TXREQ] = ev_pulse_i[EV_TXREQ] | tx_req;
    clr_vec           = (reg_we_i && !reg_addr_i) ? reg_wdata_i : '0;
    mask_we           = reg_we_i && reg_addr_i;
  end

  for (genvar i = 0; i < NUM_EV; i++) begin : g_evt
    spi_evt_bit u_bit (
      .clk   (clk),
      .rst_n (rst_n),
      .set_i (set_vec[i]),
      .clr_i (clr_vec[i]),
      .q_o   (event_o[i])
    );
  end

  spi_evt_mask #(.W(NUM_EV)) u_mask (
    .clk     (clk),
    .rst_n   (rst_n),
    .we_i    (mask_we),
    .wdata_i (reg_wdata_i),
    .q_o     (mask_o)
  );

  always_comb begin
    irq_pend_o = |(event_o & ~mask_o);
    irq_nxt    = irq_pend_o;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_o <= 1'b0;
    else        irq_o <= irq_nxt;
  end
endmodule

// File: rtl/spi_evt_irq_chk.sv
module spi_evt_irq_chk
  import spi_evt_pkg::*;
#(
  parameter int LVL_W = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic [NUM_EV-1:0] ev_pulse_i,
  input logic [LVL_W-1:0]  rx_level_i,
  input logic [LVL_W-1:0]  rx_thr_i,
  input logic              reg_we_i,
  input logic              reg_addr_i,
  input logic [NUM_EV-1:0] reg_wdata_i,
  input logic [NUM_EV-1:0] event_o,
  input logic [NUM_EV-1:0] mask_o,
  input logic              irq_o,
  input logic              irq_pend_o
);
  // R2 and R4: a pulsed bit is set after the edge, whether or not a clear hit it too
  p_pulse_sets_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_pulse_i != '0) |=> ((event_o & $past(ev_pulse_i)) == $past(ev_pulse_i)));

  // R2: with no clear write, no set bit drops
  p_sticky_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_we_i && !reg_addr_i) |=> ((event_o & $past(event_o)) == $past(event_o)));

  // R3: written ones without a set source end up cleared
  p_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we_i && !reg_addr_i) |=>
      ((event_o & $past(reg_wdata_i & ~ev_pulse_i) & ~REQ_BITS) == '0));

  // R5: a mask write loads the mask word
  p_mask_load_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we_i && reg_addr_i) |=> (mask_o == $past(reg_wdata_i)));

  // R7: the interrupt line trails the pending status by one cycle
  p_irq_delay_r7: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (irq_o == $past(irq_pend_o)));

  // R8: the receive level at or above threshold raises the receive request
  p_rx_req_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_level_i >= rx_thr_i) |=> event_o[EV_RXREQ]);
endmodule

bind spi_evt_irq spi_evt_irq_chk #(.LVL_W(LVL_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .ev_pulse_i  (ev_pulse_i),
  .rx_level_i  (rx_level_i),
  .rx_thr_i    (rx_thr_i),
  .reg_we_i    (reg_we_i),
  .reg_addr_i  (reg_addr_i),
  .reg_wdata_i (reg_wdata_i),
  .event_o     (event_o),
  .mask_o      (mask_o),
  .irq_o       (irq_o),
  .irq_pend_o  (irq_pend_o)
);

// File: tb/spi_evt_irq_bench.sv
`timescale 1ns/1ps
module spi_evt_irq_bench;
  localparam int DEPTH = 16;
  localparam int LW    = $clog2(DEPTH + 1);
  localparam int NE    = 9;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [NE-1:0] ev_pulse;
  logic [LW-1:0] rx_level, tx_level, rx_thr, tx_thr;
  logic          we, addr;
  logic [NE-1:0] wdata;
  logic [NE-1:0] event_w, mask_w;
  logic          irq, pend, rx_empty, tx_full;

  int tests = 0;
  int fails = 0;
  bit done  = 1'b0;

  always #2.5 clk = ~clk;

  spi_evt_irq #(.FIFO_DEPTH(DEPTH)) u_spi_evt_irq (
    .clk(clk), .rst_n(rst_n), .ev_pulse_i(ev_pulse),
    .rx_level_i(rx_level), .tx_level_i(tx_level),
    .rx_thr_i(rx_thr), .tx_thr_i(tx_thr),
    .reg_we_i(we), .reg_addr_i(addr), .reg_wdata_i(wdata),
    .event_o(event_w), .mask_o(mask_w), .irq_o(irq), .irq_pend_o(pend),
    .rx_empty_o(rx_empty), .tx_full_o(tx_full)
  );

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic a, input logic [NE-1:0] d);
    we = 1'b1; addr = a; wdata = d;
    step();
    we = 1'b0; wdata = '0;
  endtask

  task automatic t_reset();
    check("R1 event", event_w, 0);
    check("R1 mask", mask_w, 9'h1FF);
    check("R1 irq", irq, 0);
    check("R1 pend", pend, 0);
  endtask

  task automatic t_pulses();
    for (int i = 0; i < NE; i++) begin
      if (i == 4 || i == 7) continue;
      ev_pulse = NE'(1) << i;
      step();
      ev_pulse = '0;
      step();
      check($sformatf("R2 sticky bit %0d", i), event_w, 32'(NE'(1) << i));
      wr(1'b0, '1);
    end
  endtask

  task automatic t_partial_clear();
    ev_pulse = 9'h14F;
    step();
    ev_pulse = '0;
    wr(1'b0, 9'h005);
    check("R3 partial clear", event_w, 9'h14A);
    wr(1'b0, 9'h000);
    check("R3 zero write", event_w, 9'h14A);
    wr(1'b0, '1);
    check("R11 clear all", event_w, 0);
  endtask

  task automatic t_set_wins();
    ev_pulse = 9'h001;
    step();
    ev_pulse = 9'h001;
    wr(1'b0, 9'h001);
    ev_pulse = '0;
    check("R4 set wins", event_w[0], 1);
    wr(1'b0, '1);
    check("R4 cleared after", event_w, 0);
  endtask

  task automatic t_mask_irq();
    ev_pulse = 9'h004;
    step();
    ev_pulse = '0;
    check("R5 masked still recorded", event_w, 9'h004);
    check("R6 masked no pend", pend, 0);
    step();
    check("R6 masked no irq", irq, 0);
    wr(1'b0, '1);
    wr(1'b1, 9'h1FE);
    check("R5 mask load", mask_w, 9'h1FE);
    ev_pulse = 9'h001;
    step();
    ev_pulse = '0;
    check("R6 pend same cycle", pend, 1);
    check("R7 irq not yet", irq, 0);
    step();
    check("R7 irq one cycle later", irq, 1);
    wr(1'b0, 9'h001);
    check("R6 pend drops", pend, 0);
    check("R7 irq still high", irq, 1);
    step();
    check("R7 irq falls", irq, 0);
    wr(1'b1, '1);
  endtask

  task automatic t_requests();
    rx_level = 5'd7;
    step();
    check("R8 below threshold", event_w[7], 0);
    rx_level = 5'd8;
    step();
    check("R8 at threshold", event_w[7], 1);
    rx_level = 5'd0;
    wr(1'b0, '1);
    check("R8 clear after level drop", event_w, 0);
    tx_level = 5'd9;
    step();
    check("R9 above threshold", event_w[4], 0);
    tx_level = 5'd8;
    step();
    check("R9 at threshold", event_w[4], 1);
    wr(1'b0, 9'h010);
    check("R9 held by condition", event_w[4], 1);
    tx_level = 5'd12;
    wr(1'b0, '1);
    check("R9 cleared", event_w, 0);
  endtask

  task automatic t_flags();
    rx_level = 5'd0; tx_level = 5'd16;
    #1;
    check("R10 rx empty", rx_empty, 1);
    check("R10 tx full", tx_full, 1);
    rx_level = 5'd1; tx_level = 5'd15;
    #1;
    check("R10 rx not empty", rx_empty, 0);
    check("R10 tx not full", tx_full, 0);
    rx_level = 5'd0; tx_level = 5'd12;
    step();
    wr(1'b0, '1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      tests++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; ev_pulse = '0; we = 1'b0; addr = 1'b0; wdata = '0;
    rx_level = 5'd0; tx_level = 5'd12; rx_thr = 5'd8; tx_thr = 5'd8;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    step();
    t_pulses();
    t_partial_clear();
    t_set_wins();
    t_mask_irq();
    t_requests();
    t_flags();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule